// File: doc/BRIEF.md
# Extended-Precision Significand Normalizer

This block takes an unpacked floating-point operand and returns it normalized. The operand has three parts: a 128-bit significand, a signed 32-bit exponent and a 3-bit class code. When the class is normal, the block shifts the significand until its leading one sits at bit 112, which gives a 113-bit significand in a 128-bit container. It moves the exponent by the same number of positions, so the value the operand represents does not change. The leading one may start above or below bit 112, so the shift runs in either direction.

A normal operand with an all-zero significand is relabelled as zero. Operands of every other class leave the block as they entered it.

The block is one registered stage. A valid input produces its result, marked by the output valid, on the next clock edge. Rounding, packing and exception flags belong to later stages. The right shift drops low bits without keeping them, so callers must pass operands whose bits below the shift are zero whenever the leading one is above bit 112.

Top module: `sig_norm`

## Requirements
- R1: While rst_ni is low, valid_o, class_o, exp_o and sig_o are all zero.
- R2: valid_o equals valid_i delayed by exactly one clock edge. Every accepted operand yields exactly one result, in input order.
- R3: Class codes are: 0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signaling NaN. An operand with any code other than 1 comes out with the same class, exponent and significand.
- R4: A normal operand whose significand is all zero comes out with class 0. Its exponent and significand are unchanged.
- R5: A normal operand with a nonzero significand comes out with class 1. Bit 112 of sig_o is set and bits 127..113 are clear.
- R6: When the leading one of a normal operand is at bit p < 112, the significand is shifted left by 112-p and the vacated low bits are zero. The exponent decreases by 112-p.
- R7: When the leading one is at bit p > 112, the significand is shifted right by p-112 and the bits shifted out are discarded. The exponent increases by p-112.
- R8: A normal operand whose leading one is already at bit 112 comes out with its significand and exponent unchanged.
- R9: The exponent adjustment wraps modulo 2^32 (two's complement). No indication is given on overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand present on the inputs |
| class_i | input | 3 | Operand class code |
| exp_i | input | 32 | Signed operand exponent |
| sig_i | input | 128 | Operand significand, bit 127 most significant |
| valid_o | output | 1 | Result present on the outputs |
| class_o | output | 3 | Result class code |
| exp_o | output | 32 | Adjusted signed exponent |
| sig_o | output | 128 | Normalized significand |

## Verification
The cases hardest to reach from the ports lie at the two ends of the shift range. One is a leading one at bit 0, which needs the full 112-position left shift. The other is a leading one at bit 127, which needs a 15-position right shift that discards set low bits. The same shifts must also carry the exponent across its signed wrap point. Directed operands put the leading one at exactly those bits, fill the bits below it with set ones, and use exponents a few counts from the signed limits. A sweep then places the leading one at each of the 128 positions with random bits beneath it, so every shift amount and both directions are covered.

// File: rtl/sig_norm_pkg.sv
package sig_norm_pkg;
  localparam int unsigned CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_ZERO   = 3'd0,
    CLS_NORMAL = 3'd1,
    CLS_INF    = 3'd2,
    CLS_QNAN   = 3'd3,
    CLS_SNAN   = 3'd4
  } fp_cls_e;
endpackage

// File: rtl/sig_norm_lead.sv
module sig_norm_lead #(
  parameter int unsigned W     = 128,
  localparam int unsigned POS_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic [POS_W-1:0] pos_o,
  output logic             zero_o
);
  // highest set bit wins: later iterations overwrite
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) pos_o = POS_W'(i);
    end
  end

  assign zero_o = ~|vec_i;
endmodule

// File: rtl/sig_norm_shift.sv
module sig_norm_shift #(
  parameter int unsigned W     = 128,
  parameter int unsigned AMT_W = 7
) (
  input  logic [W-1:0]     data_i,
  input  logic             left_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [W-1:0]     data_o
);
  logic [W-1:0] stage [AMT_W+1];

  assign stage[0] = data_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    always_comb begin
      if (!amt_i[k])   stage[k+1] = stage[k];
      else if (left_i) stage[k+1] = stage[k] << STEP;
      else             stage[k+1] = stage[k] >> STEP;
    end
  end

  assign data_o = stage[AMT_W];
endmodule

// File: rtl/sig_norm.sv
module sig_norm
  import sig_norm_pkg::*;
#(
  parameter int unsigned SIG_W    = 128,
  parameter int unsigned EXP_W    = 32,
  parameter int unsigned LEAD_POS = 112
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [CLS_W-1:0]        class_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0]        sig_i,
  output logic                    valid_o,
  output logic [CLS_W-1:0]        class_o,
  output logic signed [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0]        sig_o
);
  localparam int unsigned POS_W = $clog2(SIG_W);
  localparam logic [POS_W-1:0] TGT = POS_W'(LEAD_POS);

  logic [POS_W-1:0]        lead_pos;
  logic                    sig_zero;
  logic                    go_left;
  logic [POS_W-1:0]        amt;
  logic [SIG_W-1:0]        shifted;
  logic signed [EXP_W-1:0] delta;
  logic [CLS_W-1:0]        cls_n;
  logic signed [EXP_W-1:0] exp_n;
  logic [SIG_W-1:0]        sig_n;

  sig_norm_lead #(.W(SIG_W)) u_lead (
    .vec_i  (sig_i),
    .pos_o  (lead_pos),
    .zero_o (sig_zero)
  );

  assign go_left = lead_pos < TGT;
  assign amt     = go_left ? (TGT - lead_pos) : (lead_pos - TGT);

  sig_norm_shift #(.W(SIG_W), .AMT_W(POS_W)) u_shift (
    .data_i (sig_i),
    .left_i (go_left),
    .amt_i  (amt),
    .data_o (shifted)
  );

  // signed displacement of the leading one from its target
  assign delta = $signed(EXP_W'(lead_pos)) - $signed(EXP_W'(LEAD_POS));

  always_comb begin
    cls_n = class_i;
    exp_n = exp_i;
    sig_n = sig_i;
    if (class_i == CLS_NORMAL) begin
      if (sig_zero) begin
        cls_n = CLS_ZERO;
      end else begin
        exp_n = exp_i + delta;
        sig_n = shifted;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      class_o <= '0;
      exp_o   <= '0;
      sig_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        class_o <= cls_n;
        exp_o   <= exp_n;
        sig_o   <= sig_n;
      end
    end
  end
endmodule

// File: rtl/sig_norm_chk.sv
module sig_norm_chk
  import sig_norm_pkg::*;
#(
  parameter int unsigned SIG_W    = 128,
  parameter int unsigned EXP_W    = 32,
  parameter int unsigned LEAD_POS = 112
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic [CLS_W-1:0]        class_i,
  input logic signed [EXP_W-1:0] exp_i,
  input logic [SIG_W-1:0]        sig_i,
  input logic                    valid_o,
  input logic [CLS_W-1:0]        class_o,
  input logic signed [EXP_W-1:0] exp_o,
  input logic [SIG_W-1:0]        sig_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> !valid_o); // R1

  AST_VALID_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2

  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R2

  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i != CLS_NORMAL) |=>
      (class_o == $past(class_i) && exp_o == $past(exp_i) && sig_o == $past(sig_i))); // R3

  AST_ZERO_RECLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i == CLS_NORMAL && sig_i == '0) |=>
      (class_o == CLS_ZERO && exp_o == $past(exp_i) && sig_o == '0)); // R4

  AST_LEAD_PLACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && class_o == CLS_NORMAL) |-> ((sig_o >> LEAD_POS) == SIG_W'(1))); // R5

  AST_ALIGNED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && class_i == CLS_NORMAL && (sig_i >> LEAD_POS) == SIG_W'(1)) |=>
      (sig_o == $past(sig_i) && exp_o == $past(exp_i))); // R8
endmodule

bind sig_norm sig_norm_chk #(
  .SIG_W(SIG_W), .EXP_W(EXP_W), .LEAD_POS(LEAD_POS)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .class_i (class_i),
  .exp_i   (exp_i),
  .sig_i   (sig_i),
  .valid_o (valid_o),
  .class_o (class_o),
  .exp_o   (exp_o),
  .sig_o   (sig_o)
);

// File: tb/sig_norm_bench.sv
`timescale 1ns/1ps
module sig_norm_bench;
  typedef struct {
    logic [2:0]   c;
    logic [31:0]  e;
    logic [127:0] s;
    string        r;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [2:0]   class_i = '0;
  logic [31:0]  exp_i = '0;
  logic [127:0] sig_i = '0;
  logic         valid_o;
  logic [2:0]   class_o;
  logic [31:0]  exp_o;
  logic [127:0] sig_o;

  item_t sb[$];
  int n_chk = 0;
  int n_bad = 0;
  int n_sent = 0;
  int n_seen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sig_norm u_sig_norm (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .class_i(class_i),
    .exp_i(exp_i), .sig_i(sig_i), .valid_o(valid_o), .class_o(class_o),
    .exp_o(exp_o), .sig_o(sig_o)
  );

  function automatic item_t model(logic [2:0] c, logic [31:0] e, logic [127:0] s, string r);
    item_t m;
    int p;
    m.c = c; m.e = e; m.s = s; m.r = r;
    if (c == 3'd1) begin
      if (s == '0) m.c = 3'd0;
      else begin
        p = 0;
        for (int i = 0; i < 128; i++) if (s[i]) p = i;
        if (p >= 112) m.s = s >> (p - 112);
        else m.s = s << (112 - p);
        m.e = e + 32'(p - 112);
      end
    end
    return m;
  endfunction

  task automatic send(logic [2:0] c, logic [31:0] e, logic [127:0] s, string r);
    @(negedge clk);
    valid_i = 1'b1; class_i = c; exp_i = e; sig_i = s;
    sb.push_back(model(c, e, s, r));
    n_sent++;
  endtask

  task automatic gap();
    @(negedge clk);
    valid_i = 1'b0; class_i = '0; exp_i = '0; sig_i = '0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // monitor: compare each result against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && valid_o) begin
        n_seen++;
        n_chk++;
        if (sb.size() == 0) begin
          n_bad++;
          $display("FAIL R2 unexpected result act cls=%0d exp=%h sig=%h exp none",
                   class_o, exp_o, sig_o);
        end else begin
          item_t x;
          x = sb.pop_front();
          if (class_o !== x.c || exp_o !== x.e || sig_o !== x.s) begin
            n_bad++;
            $display("FAIL %s act cls=%0d exp=%h sig=%h expected cls=%0d exp=%h sig=%h",
                     x.r, class_o, exp_o, sig_o, x.c, x.e, x.s);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog expired act running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [127:0] v;
    repeat (3) @(negedge clk);
    n_chk++;
    if (valid_o !== 1'b0 || class_o !== '0 || exp_o !== '0 || sig_o !== '0) begin
      n_bad++;
      $display("FAIL R1 reset act v=%b c=%0d e=%h s=%h expected all zero",
               valid_o, class_o, exp_o, sig_o);
    end
    rst_n = 1'b1;
    gap();

    send(3'd0, 32'h1234_5678, 128'h0, "R3 zero");
    send(3'd2, 32'h0000_7fff, {4{32'hdead_beef}}, "R3 inf");
    send(3'd3, 32'hffff_fff0, 128'h1, "R3 qnan");
    send(3'd4, 32'h8000_0000, {32'h7fff_ffff, {3{32'hffff_ffff}}}, "R3 snan");
    gap();
    send(3'd1, 32'h0000_0044, 128'h0, "R4 normal zero");
    send(3'd1, 32'h0000_0010, {32'h0001_2345, 32'h6789_abcd, 64'h1}, "R8 aligned");
    send(3'd1, 32'h0000_0000, 128'h1, "R6 lead bit0");
    send(3'd1, 32'h0000_0100, {32'h0, 32'h8000_0000, 64'h3}, "R6 lead bit95");
    send(3'd1, 32'h0000_0000, {32'h0000_8000, 96'hffff}, "R6 lead bit111");
    send(3'd1, 32'h0000_0000, {128{1'b1}}, "R7 lead bit127 drops");
    send(3'd1, 32'hffff_ff00, {32'h0100_0000, 96'hff}, "R7 lead bit120");
    send(3'd1, 32'h0000_0005, {32'h0002_0000, 96'h1}, "R7 lead bit113");
    gap();
    gap();
    send(3'd1, 32'h7fff_fffa, {1'b1, 127'h0}, "R9 wrap up");
    send(3'd1, 32'h8000_0000, 128'h1, "R9 wrap down");
    send(3'd1, 32'h8000_0060, 128'h3, "R9 near limit");

    for (int p = 0; p < 128; p++) begin
      v = {$urandom, $urandom, $urandom, $urandom};
      if (p < 127) v = v & ((128'h1 << p) - 128'h1);
      else v = '0;
      v[p] = 1'b1;
      send(3'd1, $urandom, v, "R5 sweep");
      if (p % 17 == 0) gap();
    end
    gap();
    repeat (3) @(negedge clk);

    n_chk++;
    if (sb.size() != 0 || n_seen != n_sent) begin
      n_bad++;
      $display("FAIL R2 result count act %0d expected %0d", n_seen, n_sent);
    end
    done = 1;
    summary();
    $finish;
  end
endmodule